// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block produces a level interrupt at a regular, software-chosen interval. It counts strobes of a one-millisecond tick enable that arrives from elsewhere in the clock domain. When the count reaches a programmed reload value, one period ends, the interrupt goes high and the next period begins without any software action. The interval is therefore (reload + 1) milliseconds, which is a rate of 1000 / (reload + 1) interrupts per second.

Software uses a small register port. A write to the reload register stores a new interval, drops any pending interrupt and starts a fresh period from zero. A read of the count register acknowledges the interrupt and returns zero. After reset the timer stays idle and does not interrupt until the first reload write.

Two state machines form the design:
- **Run machine.** It has the states `RUN_IDLE` and `RUN_ACTIVE`. The transition *arm* (`RUN_IDLE` → `RUN_ACTIVE`) is taken on any reload write. `RUN_ACTIVE` holds for as long as reset is released.
- **Interrupt machine.** It has the states `IRQ_LOW` and `IRQ_HIGH`.
  - *raise* (`IRQ_LOW` → `IRQ_HIGH`) happens on a period expiry.
  - *restart-clear* (`IRQ_HIGH` → `IRQ_LOW`) happens on a reload write.
  - *acknowledge* (`IRQ_HIGH` → `IRQ_LOW`) happens on a count read in a cycle with no expiry.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset `timer_irq` is 0, the stored reload value is 0 and the timer is idle. While idle, tick strobes never raise `timer_irq`.
- R2: A write whose word address matches byte offset 0x228 stores `reg_wdata[8:0]` as the reload value. Bits 31..9 are ignored, so writing 0xFFFFFE03 gives a reload of 3.
- R3: A reload write drops `timer_irq` on the next cycle and restarts the period from zero, whatever count had been reached before.
- R4: After a restart, `timer_irq` rises on the (reload + 1)-th tick strobe. The following period then begins automatically with the same length.
- R5: The period counter advances only in cycles where `ms_tick` is 1. Any number of clock cycles without a strobe leave the remaining period unchanged.
- R6: A read whose word address matches byte offset 0x230 drops `timer_irq` on the next cycle. Such a read returns 0 on `reg_rdata`.
- R7: When a count read and a period expiry occur in the same cycle, the expiry wins and `timer_irq` is 1 afterwards.
- R8: When a reload write and a tick strobe occur in the same cycle, the write wins. The strobe is not counted and does not expire a period.
- R9: Reads and writes at any other offset change neither `timer_irq` nor the reload value nor the count, and every read returns 0.
- R10: Once raised, `timer_irq` holds at 1 through further expiries until a count read or a reload write lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | AW (12) | Byte address of the access; bits 1..0 are ignored |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, combinational, always 0 |
| timer_irq | output | 1 | Timer interrupt level |

## Verification
The checker assumes that all inputs are free of X once reset is released and that they change only between rising edges. It also takes `ms_tick` to be a single-cycle strobe, so every strobe adds exactly one count. The bench drives every input on the falling edge and holds each strobe for one cycle. It separates ordinary accesses with idle cycles and puts a read or a write in the same cycle as a strobe only in the scenarios that test those coincidences.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    // Run machine: the timer is idle until software first programs it.
    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    // Interrupt machine: the level seen on timer_irq.
    typedef enum logic {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;

    // Byte offsets decoded by software drivers.
    localparam int unsigned RELOAD_OFS_DEF = 32'h228;
    localparam int unsigned COUNT_OFS_DEF  = 32'h230;

endpackage

// File: rtl/pit_regdec.sv
`timescale 1ns/1ps
module pit_regdec #(
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned CW         = 9,
    parameter int unsigned RELOAD_OFS = pit_pkg::RELOAD_OFS_DEF,
    parameter int unsigned COUNT_OFS  = pit_pkg::COUNT_OFS_DEF
) (
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          reload_wr,
    output logic          count_rd,
    output logic [CW-1:0] reload_val,
    output logic [DW-1:0] reg_rdata
);

    localparam int unsigned WAW = AW - 2;
    localparam logic [WAW-1:0] RELOAD_WORD = WAW'(RELOAD_OFS >> 2);
    localparam logic [WAW-1:0] COUNT_WORD  = WAW'(COUNT_OFS >> 2);

    logic [WAW-1:0] word_addr;
    logic           hit_reload;
    logic           hit_count;
    logic           unused_bits;

    assign word_addr  = reg_addr[AW-1:2];
    assign hit_reload = (word_addr == RELOAD_WORD);
    assign hit_count  = (word_addr == COUNT_WORD);

    assign reload_wr  = reg_wr & hit_reload;
    assign count_rd   = reg_rd & hit_count;

    // Only the low CW bits of the write data are kept.
    assign reload_val = reg_wdata[CW-1:0];

    // No register is readable; the count read returns zero.
    assign reg_rdata  = '0;

    assign unused_bits = ^{reg_addr[1:0], reg_wdata[DW-1:CW]};

endmodule

// File: rtl/pit_period.sv
`timescale 1ns/1ps
module pit_period
    import pit_pkg::*;
#(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          reload_wr,
    input  logic [CW-1:0] reload_val,
    output logic          expire,
    output logic          running,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] reload_q
);

    run_state_e run_q, run_d;
    logic       at_limit;
    logic       step;

    // Next-state logic of the run machine.
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_IDLE:   if (reload_wr) run_d = RUN_ACTIVE;
            RUN_ACTIVE: run_d = RUN_ACTIVE;
            default:    run_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= RUN_IDLE;
        else        run_q <= run_d;
    end

    assign running  = (run_q == RUN_ACTIVE);
    assign at_limit = (cnt_q == reload_q);
    // A write in the same cycle takes precedence over the strobe.
    assign step     = running & ms_tick & ~reload_wr;
    assign expire   = step & at_limit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (reload_wr) begin
            reload_q <= reload_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_wr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pit_irq_fsm.sv
`timescale 1ns/1ps
module pit_irq_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic count_rd,
    input  logic reload_wr,
    output logic timer_irq
);

    irq_state_e irq_q, irq_d;

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_LOW: begin
                if (expire) irq_d = IRQ_HIGH;
            end
            IRQ_HIGH: begin
                if (reload_wr)                irq_d = IRQ_LOW;
                else if (count_rd && !expire) irq_d = IRQ_LOW;
            end
            default: irq_d = IRQ_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= IRQ_LOW;
        else        irq_q <= irq_d;
    end

    always_comb begin
        unique case (irq_q)
            IRQ_HIGH: timer_irq = 1'b1;
            default:  timer_irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/periodic_irq_timer.sv
`timescale 1ns/1ps
module periodic_irq_timer #(
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned CW         = 9,
    parameter int unsigned RELOAD_OFS = pit_pkg::RELOAD_OFS_DEF,
    parameter int unsigned COUNT_OFS  = pit_pkg::COUNT_OFS_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          timer_irq
);

    logic          reload_wr;
    logic          count_rd;
    logic [CW-1:0] reload_val;
    logic          expire;
    logic          running;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_q;

    pit_regdec #(
        .AW(AW), .DW(DW), .CW(CW),
        .RELOAD_OFS(RELOAD_OFS), .COUNT_OFS(COUNT_OFS)
    ) i_regdec (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reload_wr (reload_wr),
        .count_rd  (count_rd),
        .reload_val(reload_val),
        .reg_rdata (reg_rdata)
    );

    pit_period #(.CW(CW)) i_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .reload_wr (reload_wr),
        .reload_val(reload_val),
        .expire    (expire),
        .running   (running),
        .cnt_q     (cnt_q),
        .reload_q  (reload_q)
    );

    pit_irq_fsm i_irq_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .count_rd (count_rd),
        .reload_wr(reload_wr),
        .timer_irq(timer_irq)
    );

endmodule

// File: rtl/pit_checker.sv
`timescale 1ns/1ps
module pit_checker #(
    parameter int unsigned CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_tick,
    input logic          reload_wr,
    input logic          count_rd,
    input logic          expire,
    input logic          running,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] reload_q,
    input logic          timer_irq
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !timer_irq);

    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> !timer_irq);

    a_r4_expire_raises: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> timer_irq);

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q <= reload_q));

    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !reload_wr) |=> $stable(cnt_q));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (count_rd && !expire) |=> !timer_irq);

    a_r10_rise_only_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq) |-> $past(expire));

    a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !count_rd && !reload_wr) |=> timer_irq);

endmodule

bind periodic_irq_timer pit_checker #(.CW(CW)) i_pit_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .reload_wr(reload_wr),
    .count_rd (count_rd),
    .expire   (expire),
    .running  (running),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .timer_irq(timer_irq)
);

// File: tb/test_periodic_irq_timer.sv
`timescale 1ns/1ps
module test_periodic_irq_timer;

    localparam logic [11:0] OFS_RELOAD = 12'h228;
    localparam logic [11:0] OFS_COUNT  = 12'h230;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        timer_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    periodic_irq_timer i_periodic_irq_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .timer_irq(timer_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access cycle; the result settles at the following falling edge.
    task automatic cyc(input logic wr, input logic rd, input logic tk,
                       input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rdv);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; ms_tick = tk; reg_addr = a; reg_wdata = d;
        #1 rdv = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        logic [31:0] dummy;
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, '0, '0, dummy);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        cyc(1'b1, 1'b0, 1'b0, a, d, dummy);
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
        cyc(1'b0, 1'b1, 1'b0, a, '0, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq after reset", 32'(timer_irq), 0);
        ticks(5);
        check("R1 idle timer ignores ticks", 32'(timer_irq), 0);
        rd_reg(OFS_COUNT, v);
        check("R6 count read data", v, 0);
    endtask

    task automatic t_period;
        logic [31:0] v;
        wr_reg(OFS_RELOAD, 32'd3);
        ticks(3);
        check("R4 no irq before period end", 32'(timer_irq), 0);
        ticks(1);
        check("R4 irq on 4th tick", 32'(timer_irq), 1);
        rd_reg(OFS_COUNT, v);
        check("R6 ack read data", v, 0);
        check("R6 ack clears irq", 32'(timer_irq), 0);
        ticks(3);
        check("R4 second period not yet over", 32'(timer_irq), 0);
        ticks(1);
        check("R4 automatic next period", 32'(timer_irq), 1);
        ticks(4);
        check("R10 irq held across expiry", 32'(timer_irq), 1);
    endtask

    task automatic t_idle_cycles;
        wr_reg(OFS_RELOAD, 32'd2);
        check("R3 write clears irq", 32'(timer_irq), 0);
        ticks(2);
        repeat (20) @(negedge clk);
        check("R5 no advance without tick", 32'(timer_irq), 0);
        ticks(1);
        check("R5 third tick expires", 32'(timer_irq), 1);
    endtask

    task automatic t_rewrite;
        ticks(1);
        wr_reg(OFS_RELOAD, 32'd2);
        check("R3 rewrite clears irq", 32'(timer_irq), 0);
        ticks(2);
        check("R3 period restarted from zero", 32'(timer_irq), 0);
        ticks(1);
        check("R3 full period after rewrite", 32'(timer_irq), 1);
    endtask

    task automatic t_upper_bits;
        wr_reg(OFS_RELOAD, 32'hFFFF_FE03);
        ticks(3);
        check("R2 upper bits ignored, early", 32'(timer_irq), 0);
        ticks(1);
        check("R2 reload of 3 gives 4 ticks", 32'(timer_irq), 1);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr_reg(OFS_RELOAD, 32'd1);
        ticks(1);
        check("R7 setup irq low", 32'(timer_irq), 0);
        cyc(1'b0, 1'b1, 1'b1, OFS_COUNT, '0, v);
        check("R7 expiry beats ack", 32'(timer_irq), 1);
        check("R6 read data during collision", v, 0);
    endtask

    task automatic t_wr_tick;
        logic [31:0] dummy;
        cyc(1'b1, 1'b0, 1'b1, OFS_RELOAD, 32'd1, dummy);
        check("R8 write with tick clears irq", 32'(timer_irq), 0);
        ticks(1);
        check("R8 tick in write cycle not counted", 32'(timer_irq), 0);
        ticks(1);
        check("R8 expiry after two ticks", 32'(timer_irq), 1);
    endtask

    task automatic t_other_offsets;
        logic [31:0] v;
        wr_reg(12'h22C, 32'd0);
        check("R9 write 0x22C ignored", 32'(timer_irq), 1);
        wr_reg(12'h220, 32'd0);
        check("R9 write 0x220 ignored", 32'(timer_irq), 1);
        rd_reg(12'h234, v);
        check("R9 read 0x234 data", v, 0);
        check("R9 read 0x234 no ack", 32'(timer_irq), 1);
        rd_reg(OFS_RELOAD, v);
        check("R9 read 0x228 data", v, 0);
        check("R9 read 0x228 no ack", 32'(timer_irq), 1);
        rd_reg(OFS_COUNT, v);
        check("R6 ack after stray accesses", 32'(timer_irq), 0);
        ticks(1);
        check("R9 reload kept, early", 32'(timer_irq), 0);
        ticks(1);
        check("R9 reload kept, expiry", 32'(timer_irq), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_idle_cycles();
        t_rewrite();
        t_upper_bits();
        t_collide();
        t_wr_tick();
        t_other_offsets();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule